// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block steps a pipelined analog-to-digital converter through conversion lists that software programs ahead of time. It holds sixteen list entries. Each entry names a positive and a negative multiplexer input, so each conversion can be differential. In split mode the entries form two lists of eight (entries 0-7 and 8-15), each started by its own request line. In chained mode they form one list of up to sixteen entries, started by request line 0. One request makes the selected list issue all of its entries, one sample per clock. The controller knows the converter's pipeline depth. It uses that depth to put each returned code into the result slot whose index matches the entry index.

The controller also handles converter power. When the block is disabled, the converter is unpowered and requests are ignored. When the block is enabled with the low-power option off, the converter stays powered once it has warmed up. With the low-power option on, the converter is powered down after use. A start-up option then selects a 24-cycle warm-up either before every single sample or once per list.

The controller state machine has these states. ST_IDLE waits for a request. ST_WAKE counts the warm-up. ST_SAMPLE issues one entry per cycle. ST_DRAIN waits for the last result. ST_DONE raises the end-of-list pulse for one cycle. The transitions are:
- ST_IDLE to ST_WAKE on an accepted request when the converter is cold.
- ST_IDLE to ST_SAMPLE on an accepted request when it is warm.
- ST_WAKE to ST_SAMPLE once the warm-up count completes.
- ST_SAMPLE to ST_WAKE after a non-final sample under per-sample warm-up.
- ST_SAMPLE to ST_DRAIN after the final entry.
- ST_DRAIN to ST_DONE when the final result is written.
- ST_DONE to ST_IDLE always.
- Any state to ST_IDLE when the block is disabled.

The host reaches the controller through a simple write/read port, using these addresses:
- 0x00 (control): bit 0 enable, bit 1 low-power, bit 2 chained, bit 3 per-sample warm-up, bits 5:4 resolution select, bit 6 hold shortening.
- 0x01: list-0 length minus one, 4 bits. Only 3 bits apply in split mode.
- 0x02: list-1 length minus one, 3 bits.
- 0x03: writing a 1 in bit s clears the lost-request flag of list s.
- 0x10+i: entry i, with bits 3:0 the positive input and bits 7:4 the negative input.
- 0x20+i: result slot i, read-only.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all busy, end, lost-request, power and sample outputs are low, and every result slot reads 0.
- R2: While the enable bit is 0, requests start nothing: no sample, no power, no busy, and no lost-request flag.
- R3: A request that finds the converter cold gives its first sample 25 cycles after the request cycle (24 warm-up cycles, then sampling). With the low-power bit at 0 and the converter already warm, the first sample comes 1 cycle after the request. Samples are only issued while the power output is high.
- R4: A running list issues its entries in ascending index order, one per cycle, unless per-sample warm-up applies. Each sample presents the entry's bits 3:0 on the positive select and bits 7:4 on the negative select.
- R5: The code returned for entry i is stored in result slot i. List 0 uses slots 0 to len0. List 1 uses slots 8 to 8+len1.
- R6: The converter latency is SRES/2+3-H cycles. SRES is 8, 10 or 12 for resolution select 0, 1 or 2-3, and H is the hold-shortening bit. The end pulse appears latency+1 cycles after the final sample.
- R7: The end pulse lasts one cycle, on the bit of the list that ran, and comes one cycle after its last result is written. That list's busy bit is high from the cycle after the request through the end pulse, and at most one busy bit is high at a time.
- R8: In chained mode, request 0 runs entries 0 to len0 (up to 16), and request 1 is ignored: no busy and no lost-request flag for list 1.
- R9: With low-power on and per-sample warm-up on, consecutive samples are 25 cycles apart, and power is low once the final sample has been issued.
- R10: With low-power on and per-sample warm-up off, every list starts with a full warm-up, after which its samples are back to back.
- R11: A request that cannot be accepted (the block is busy, or request 0 wins a same-cycle tie) sets that list's sticky lost-request flag. It leaves the running list undisturbed. Only a clear write resets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 6 | Host write address |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | 6 | Host read address |
| host_rdata | output | 16 | Host read data |
| soc_req | input | 2 | Start request per list |
| adc_power | output | 1 | Converter power enable |
| adc_sample | output | 1 | Sample strobe |
| adc_pos_sel | output | 4 | Positive input select |
| adc_neg_sel | output | 4 | Negative input select |
| adc_code | input | 12 | Code from converter pipeline |
| seq_busy | output | 2 | Per-list busy |
| seq_eos | output | 2 | Per-list end pulse |
| seq_overrun | output | 2 | Per-list sticky lost-request flag |

## Verification
The hardest case to reach is a request that arrives while a list is in flight. It must set the lost-request flag without shortening, restarting or duplicating the running list. The bench starts list 0 and, two cycles later, raises both request lines together. It then checks that exactly one end pulse follows, that exactly four samples are issued, and that both flags stay set until each is cleared separately. The warm-up timing under the two low-power options is reached by reprogramming the control register between runs. The bench then measures sample spacing from its own cycle counter.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W        = 4;
    localparam int NUM_SEQ     = 2;
    localparam int SEQ_DEPTH   = 8;
    localparam int TOTAL       = NUM_SEQ * SEQ_DEPTH;
    localparam int IDX_W       = $clog2(TOTAL);
    localparam int RES_W       = 12;
    localparam int WAKE_CYCLES = 24;
    localparam int WAKE_W      = $clog2(WAKE_CYCLES + 1);
    localparam int MAX_LAT     = 12 / 2 + 3;
    localparam int LAT_W       = $clog2(MAX_LAT + 1);
    localparam int ADDR_W      = 6;
    localparam int HOST_W      = 16;
    localparam int PAGE_W      = ADDR_W - IDX_W;

    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_LEN0    = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_LEN1    = 6'h02;
    localparam logic [ADDR_W-1:0] ADDR_OVR_CLR = 6'h03;
    localparam logic [PAGE_W-1:0] PAGE_ENTRY   = 2'd1;
    localparam logic [PAGE_W-1:0] PAGE_RESULT  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SAMPLE,
        ST_DRAIN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       shd;
        logic [1:0] res_sel;
        logic       wake_each;
        logic       chain;
        logic       sleep;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [IDX_W-1:0] idx;
    } tag_t;

    function automatic logic [LAT_W-1:0] conv_latency(input logic [1:0] res_sel,
                                                      input logic       shd);
        logic [LAT_W-1:0] half;
        unique case (res_sel)
            2'd0:    half = LAT_W'(4);
            2'd1:    half = LAT_W'(5);
            default: half = LAT_W'(6);
        endcase
        return half + LAT_W'(3) - LAT_W'(shd);
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [HOST_W-1:0]    wdata,
    input  logic [ADDR_W-1:0]    raddr,
    output logic [HOST_W-1:0]    rdata,
    output ctrl_t                ctrl,
    output logic [IDX_W-1:0]     len0,
    output logic [IDX_W-2:0]     len1,
    output logic [NUM_SEQ-1:0]   ovr_clr,
    input  logic [IDX_W-1:0]     ent_idx,
    output logic [CH_W-1:0]      ent_pos,
    output logic [CH_W-1:0]      ent_neg,
    input  logic                 res_we,
    input  logic [IDX_W-1:0]     res_idx,
    input  logic [RES_W-1:0]     res_data
);

    logic [$bits(ctrl_t)-1:0] ctrl_q;
    logic [IDX_W-1:0]         len0_q;
    logic [IDX_W-2:0]         len1_q;
    logic [2*CH_W-1:0]        ent_q [TOTAL];
    logic [RES_W-1:0]         res_q [TOTAL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            len0_q <= '0;
            len1_q <= '0;
        end else if (we) begin
            if (waddr == ADDR_CTRL) ctrl_q <= wdata[$bits(ctrl_t)-1:0];
            if (waddr == ADDR_LEN0) len0_q <= wdata[IDX_W-1:0];
            if (waddr == ADDR_LEN1) len1_q <= wdata[IDX_W-2:0];
        end
    end

    for (genvar i = 0; i < TOTAL; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (we && waddr[ADDR_W-1:IDX_W] == PAGE_ENTRY
                         && waddr[IDX_W-1:0] == IDX_W'(i)) begin
                ent_q[i] <= wdata[2*CH_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[i] <= '0;
            end else if (res_we && res_idx == IDX_W'(i)) begin
                res_q[i] <= res_data;
            end
        end
    end

    assign ctrl    = ctrl_t'(ctrl_q);
    assign len0    = len0_q;
    assign len1    = len1_q;
    assign ovr_clr = (we && waddr == ADDR_OVR_CLR) ? wdata[NUM_SEQ-1:0] : '0;
    assign ent_pos = ent_q[ent_idx][CH_W-1:0];
    assign ent_neg = ent_q[ent_idx][2*CH_W-1:CH_W];

    always_comb begin
        rdata = '0;
        if (raddr == ADDR_CTRL) begin
            rdata = HOST_W'(ctrl_q);
        end else if (raddr == ADDR_LEN0) begin
            rdata = HOST_W'(len0_q);
        end else if (raddr == ADDR_LEN1) begin
            rdata = HOST_W'(len1_q);
        end else if (raddr[ADDR_W-1:IDX_W] == PAGE_ENTRY) begin
            rdata = HOST_W'(ent_q[raddr[IDX_W-1:0]]);
        end else if (raddr[ADDR_W-1:IDX_W] == PAGE_RESULT) begin
            rdata = HOST_W'(res_q[raddr[IDX_W-1:0]]);
        end
    end

endmodule

// File: rtl/adc_seq_pipe.sv
module adc_seq_pipe
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              push_last,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [LAT_W-1:0]  lat,
    output logic              wb_valid,
    output logic              wb_last,
    output logic [IDX_W-1:0]  wb_idx
);

    tag_t tag_q [MAX_LAT];
    tag_t tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q[0] <= '0;
        end else if (flush) begin
            tag_q[0] <= '0;
        end else begin
            tag_q[0] <= '{valid: push, last: push_last, idx: push_idx};
        end
    end

    for (genvar i = 1; i < MAX_LAT; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[i] <= '0;
            end else if (flush) begin
                tag_q[i] <= '0;
            end else begin
                tag_q[i] <= tag_q[i-1];
            end
        end
    end

    // the result for a tag is present on the converter output lat cycles after its sample
    always_comb begin
        tap = '0;
        for (int i = 0; i < MAX_LAT; i++) begin
            if (LAT_W'(i + 1) == lat) tap = tag_q[i];
        end
    end

    assign wb_valid = tap.valid;
    assign wb_last  = tap.last;
    assign wb_idx   = tap.idx;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  ctrl_t               ctrl,
    input  logic [IDX_W-1:0]    len0,
    input  logic [IDX_W-2:0]    len1,
    input  logic [NUM_SEQ-1:0]  soc,
    input  logic [NUM_SEQ-1:0]  ovr_clr,
    input  logic                wb_valid,
    input  logic                wb_last,
    output logic [IDX_W-1:0]    cur_idx,
    output logic                push,
    output logic                push_last,
    output logic                flush,
    output logic                adc_power,
    output logic [NUM_SEQ-1:0]  busy,
    output logic [NUM_SEQ-1:0]  eos,
    output logic [NUM_SEQ-1:0]  overrun
);

    localparam logic [IDX_W-1:0] SEQ1_BASE = IDX_W'(SEQ_DEPTH);

    seq_state_e          state_q, state_d;
    logic                sel_q, sel_d;
    logic [IDX_W-1:0]    cur_q, cur_d;
    logic [IDX_W-1:0]    end_q, end_d;
    logic [WAKE_W-1:0]   wcnt_q, wcnt_d;
    logic                warm_q, warm_d;
    logic [NUM_SEQ-1:0]  ovr_q, ovr_d;
    logic                take0, take1, lose0, lose1;

    always_comb begin
        take0 = ctrl.en && state_q == ST_IDLE && soc[0];
        take1 = ctrl.en && state_q == ST_IDLE && soc[1] && !soc[0] && !ctrl.chain;
        lose0 = ctrl.en && soc[0] && state_q != ST_IDLE;
        lose1 = ctrl.en && soc[1] && !ctrl.chain && (state_q != ST_IDLE || soc[0]);
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        cur_d   = cur_q;
        end_d   = end_q;
        wcnt_d  = wcnt_q;
        warm_d  = warm_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl.sleep) warm_d = 1'b0;
                if (take0 || take1) begin
                    sel_d   = take1;
                    cur_d   = take1 ? SEQ1_BASE : '0;
                    end_d   = take1 ? SEQ1_BASE + IDX_W'(len1)
                                    : (ctrl.chain ? len0 : IDX_W'(len0[IDX_W-2:0]));
                    wcnt_d  = '0;
                    state_d = (warm_q && !ctrl.sleep) ? ST_SAMPLE : ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (wcnt_q == WAKE_W'(WAKE_CYCLES - 1)) begin
                    warm_d  = 1'b1;
                    state_d = ST_SAMPLE;
                end else begin
                    wcnt_d = wcnt_q + WAKE_W'(1);
                end
            end
            ST_SAMPLE: begin
                cur_d = cur_q + IDX_W'(1);
                if (cur_q == end_q) begin
                    if (ctrl.sleep) warm_d = 1'b0;
                    state_d = ST_DRAIN;
                end else if (ctrl.sleep && ctrl.wake_each) begin
                    warm_d  = 1'b0;
                    wcnt_d  = '0;
                    state_d = ST_WAKE;
                end
            end
            ST_DRAIN: begin
                if (wb_valid && wb_last) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!ctrl.en) begin
            state_d = ST_IDLE;
            warm_d  = 1'b0;
        end
        ovr_d = (ovr_q & ~ovr_clr) | {lose1, lose0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            cur_q   <= '0;
            end_q   <= '0;
            wcnt_q  <= '0;
            warm_q  <= 1'b0;
            ovr_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            cur_q   <= cur_d;
            end_q   <= end_d;
            wcnt_q  <= wcnt_d;
            warm_q  <= warm_d;
            ovr_q   <= ovr_d;
        end
    end

    always_comb begin
        cur_idx   = cur_q;
        push      = ctrl.en && state_q == ST_SAMPLE;
        push_last = cur_q == end_q;
        flush     = !ctrl.en;
        adc_power = ctrl.en && (warm_q || state_q == ST_WAKE || state_q == ST_SAMPLE);
        overrun   = ovr_q;
        busy      = '0;
        eos       = '0;
        if (state_q != ST_IDLE) busy[sel_q] = 1'b1;
        if (state_q == ST_DONE) eos[sel_q]  = 1'b1;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_waddr,
    input  logic [HOST_W-1:0]   host_wdata,
    input  logic [ADDR_W-1:0]   host_raddr,
    output logic [HOST_W-1:0]   host_rdata,
    input  logic [NUM_SEQ-1:0]  soc_req,
    output logic                adc_power,
    output logic                adc_sample,
    output logic [CH_W-1:0]     adc_pos_sel,
    output logic [CH_W-1:0]     adc_neg_sel,
    input  logic [RES_W-1:0]    adc_code,
    output logic [NUM_SEQ-1:0]  seq_busy,
    output logic [NUM_SEQ-1:0]  seq_eos,
    output logic [NUM_SEQ-1:0]  seq_overrun
);

    ctrl_t               ctrl;
    logic [IDX_W-1:0]    len0;
    logic [IDX_W-2:0]    len1;
    logic [NUM_SEQ-1:0]  ovr_clr;
    logic [IDX_W-1:0]    cur_idx;
    logic                push, push_last, flush;
    logic                wb_valid, wb_last;
    logic [IDX_W-1:0]    wb_idx;
    logic [LAT_W-1:0]    lat;
    logic                conv_en, chain_mode;

    assign lat        = conv_latency(ctrl.res_sel, ctrl.shd);
    assign conv_en    = ctrl.en;
    assign chain_mode = ctrl.chain;
    assign adc_sample = push;

    adc_seq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (host_we),
        .waddr    (host_waddr),
        .wdata    (host_wdata),
        .raddr    (host_raddr),
        .rdata    (host_rdata),
        .ctrl     (ctrl),
        .len0     (len0),
        .len1     (len1),
        .ovr_clr  (ovr_clr),
        .ent_idx  (cur_idx),
        .ent_pos  (adc_pos_sel),
        .ent_neg  (adc_neg_sel),
        .res_we   (wb_valid),
        .res_idx  (wb_idx),
        .res_data (adc_code)
    );

    adc_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .len0      (len0),
        .len1      (len1),
        .soc       (soc_req),
        .ovr_clr   (ovr_clr),
        .wb_valid  (wb_valid),
        .wb_last   (wb_last),
        .cur_idx   (cur_idx),
        .push      (push),
        .push_last (push_last),
        .flush     (flush),
        .adc_power (adc_power),
        .busy      (seq_busy),
        .eos       (seq_eos),
        .overrun   (seq_overrun)
    );

    adc_seq_pipe u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_last (push_last),
        .push_idx  (cur_idx),
        .lat       (lat),
        .wb_valid  (wb_valid),
        .wb_last   (wb_last),
        .wb_idx    (wb_idx)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                conv_en,
    input logic                chain_mode,
    input logic                adc_sample,
    input logic                adc_power,
    input logic [NUM_SEQ-1:0]  seq_busy,
    input logic [NUM_SEQ-1:0]  seq_eos,
    input logic [NUM_SEQ-1:0]  seq_overrun,
    input logic                host_we,
    input logic [ADDR_W-1:0]   host_waddr,
    input logic [HOST_W-1:0]   host_wdata
);

    assert_sample_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sample |-> adc_power);

    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_en && $past(!conv_en)) |-> (seq_busy == '0 && !adc_power && !adc_sample));

    assert_busy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seq_busy));

    assert_eos_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_eos != '0) |-> (seq_eos == seq_busy));

    assert_eos_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_eos != '0) |=> (seq_busy == '0));

    assert_overrun0_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_overrun[0] && !(host_we && host_waddr == ADDR_OVR_CLR && host_wdata[0]))
        |=> seq_overrun[0]);

    assert_overrun1_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_overrun[1] && !(host_we && host_waddr == ADDR_OVR_CLR && host_wdata[1]))
        |=> seq_overrun[1]);

    assert_chain_no_list1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && $past(chain_mode) && !$past(seq_busy[1])) |-> !seq_busy[1]);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_en     (conv_en),
    .chain_mode  (chain_mode),
    .adc_sample  (adc_sample),
    .adc_power   (adc_power),
    .seq_busy    (seq_busy),
    .seq_eos     (seq_eos),
    .seq_overrun (seq_overrun),
    .host_we     (host_we),
    .host_waddr  (host_waddr),
    .host_wdata  (host_wdata)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_waddr = '0;
    logic [15:0] host_wdata = '0;
    logic [5:0]  host_raddr = '0;
    logic [15:0] host_rdata;
    logic [1:0]  soc_req = '0;
    logic        adc_power, adc_sample;
    logic [3:0]  adc_pos_sel, adc_neg_sel;
    logic [11:0] adc_code;
    logic [1:0]  seq_busy, seq_eos, seq_overrun;

    always #2 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .soc_req(soc_req), .adc_power(adc_power), .adc_sample(adc_sample),
        .adc_pos_sel(adc_pos_sel), .adc_neg_sel(adc_neg_sel), .adc_code(adc_code),
        .seq_busy(seq_busy), .seq_eos(seq_eos), .seq_overrun(seq_overrun)
    );

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // converter stub: code = {sample number, pos, neg}, delivered lat_tb cycles later
    logic [11:0] pipe [9];
    int stub_n = 0;
    int lat_tb = 9;
    initial for (int i = 0; i < 9; i++) pipe[i] = '0;
    always @(posedge clk) begin
        pipe[0] <= adc_sample ? {stub_n[3:0], adc_pos_sel, adc_neg_sel} : 12'h0;
        for (int i = 1; i < 9; i++) pipe[i] <= pipe[i-1];
        if (adc_sample) stub_n <= stub_n + 1;
    end
    assign adc_code = pipe[lat_tb-1];

    int          nlog = 0;
    int          log_cyc [64];
    logic [11:0] log_code [64];
    int          neos = 0;
    int          eos_cyc = 0;
    logic [1:0]  eos_vec = '0;
    always @(negedge clk) begin
        if (adc_sample && nlog < 64) begin
            log_cyc[nlog]  = cyc;
            log_code[nlog] = {stub_n[3:0], adc_pos_sel, adc_neg_sel};
            nlog++;
        end
        if (seq_eos != 2'b00) begin
            eos_cyc = cyc;
            eos_vec = seq_eos;
            neos++;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic set_ctrl(input bit en, input bit slp, input bit chn, input bit each,
                            input int res, input bit shd);
        wr(6'h00, {9'd0, shd, res[1:0], each, chn, slp, en});
        lat_tb = (res == 0 ? 4 : (res == 1 ? 5 : 6)) + 3 - int'(shd);
    endtask

    task automatic set_entry(input int i, input logic [3:0] pos, input logic [3:0] neg);
        wr(6'h10 + 6'(i), {8'd0, neg, pos});
    endtask

    task automatic fire(input logic [1:0] v, output int c0);
        nlog = 0;
        @(negedge clk);
        soc_req = v;
        c0 = cyc;
        @(negedge clk);
        soc_req = 2'b00;
    endtask

    task automatic wait_end(input int n0, input string req);
        int k = 0;
        while (neos == n0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(req, "end pulse seen", longint'(neos > n0), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_slots(input int base, input int n, input string req);
        logic [15:0] d;
        for (int k = 0; k < n; k++) begin
            rd(6'h20 + 6'(base + k), d);
            chk(req, $sformatf("result slot %0d", base + k), d, {4'd0, log_code[k]});
        end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R1", "busy", seq_busy, 0);
        chk("R1", "eos", seq_eos, 0);
        chk("R1", "overrun", seq_overrun, 0);
        chk("R1", "power", adc_power, 0);
        chk("R1", "sample", adc_sample, 0);
        rd(6'h20, d); chk("R1", "slot 0", d, 0);
        rd(6'h2F, d); chk("R1", "slot 15", d, 0);
    endtask

    task automatic t_disabled;
        int c0;
        set_ctrl(0, 0, 0, 0, 2, 0);
        fire(2'b11, c0);
        chk("R2", "busy after request", seq_busy, 0);
        repeat (40) @(negedge clk);
        chk("R2", "samples", nlog, 0);
        chk("R2", "overrun", seq_overrun, 0);
        chk("R2", "power", adc_power, 0);
    endtask

    task automatic t_split_list0;
        int c0, n0;
        set_ctrl(1, 0, 0, 0, 2, 0);
        set_entry(0, 4'h1, 4'h9); set_entry(1, 4'h2, 4'hA);
        set_entry(2, 4'h3, 4'hB); set_entry(3, 4'h7, 4'h0);
        wr(6'h01, 16'd3);
        n0 = neos;
        fire(2'b01, c0);
        chk("R7", "busy during run", seq_busy, 2'b01);
        wait_end(n0, "R7");
        chk("R4", "sample count", nlog, 4);
        chk("R3", "cold first sample delay", log_cyc[0] - c0, 25);
        for (int k = 1; k < 4; k++)
            chk("R4", $sformatf("gap before sample %0d", k), log_cyc[k] - log_cyc[k-1], 1);
        chk("R4", "pos select entry 0", log_code[0][7:4], 4'h1);
        chk("R4", "neg select entry 0", log_code[0][3:0], 4'h9);
        chk("R4", "pos select entry 3", log_code[3][7:4], 4'h7);
        chk("R6", "end after final sample", eos_cyc - log_cyc[3], 10);
        chk("R7", "end bit", eos_vec, 2'b01);
        chk("R7", "busy after end", seq_busy, 0);
        check_slots(0, 4, "R5");
        n0 = neos;
        fire(2'b01, c0);
        wait_end(n0, "R3");
        chk("R3", "warm first sample delay", log_cyc[0] - c0, 1);
    endtask

    task automatic t_split_list1;
        int c0, n0;
        set_ctrl(1, 0, 0, 0, 0, 1);
        set_entry(8, 4'h4, 4'h5); set_entry(9, 4'h6, 4'h7); set_entry(10, 4'hC, 4'hD);
        wr(6'h02, 16'd2);
        n0 = neos;
        fire(2'b10, c0);
        chk("R7", "list 1 busy", seq_busy, 2'b10);
        wait_end(n0, "R5");
        chk("R5", "list 1 samples", nlog, 3);
        chk("R5", "list 1 first pos", log_code[0][7:4], 4'h4);
        chk("R6", "short latency end", eos_cyc - log_cyc[2], 7);
        chk("R7", "list 1 end bit", eos_vec, 2'b10);
        check_slots(8, 3, "R5");
    endtask

    task automatic t_chain;
        int c0, n0;
        set_ctrl(1, 0, 1, 0, 1, 0);
        for (int i = 0; i < 16; i++) set_entry(i, 4'h5, 4'h2);
        wr(6'h01, 16'd15);
        n0 = neos;
        fire(2'b11, c0);
        chk("R8", "only list 0 busy", seq_busy, 2'b01);
        wait_end(n0, "R8");
        chk("R8", "chained samples", nlog, 16);
        chk("R8", "list 1 not flagged", seq_overrun, 0);
        chk("R6", "medium latency end", eos_cyc - log_cyc[15], 9);
        check_slots(0, 16, "R8");
    endtask

    task automatic t_overrun;
        int c0, n0;
        set_ctrl(1, 0, 0, 0, 2, 0);
        wr(6'h01, 16'd3);
        n0 = neos;
        fire(2'b01, c0);
        @(negedge clk);
        soc_req = 2'b11;
        @(negedge clk);
        soc_req = 2'b00;
        chk("R11", "both lost flags", seq_overrun, 2'b11);
        wait_end(n0, "R11");
        chk("R11", "single end pulse", neos - n0, 1);
        chk("R11", "run undisturbed", nlog, 4);
        wr(6'h03, 16'h0001);
        chk("R11", "clear list 0 only", seq_overrun, 2'b10);
        wr(6'h03, 16'h0002);
        chk("R11", "clear list 1", seq_overrun, 2'b00);
        n0 = neos;
        fire(2'b11, c0);
        wait_end(n0, "R11");
        chk("R11", "tie won by list 0", eos_vec, 2'b01);
        chk("R11", "tie loser flagged", seq_overrun, 2'b10);
        wr(6'h03, 16'h0003);
    endtask

    task automatic t_sleep_each;
        int c0, n0;
        set_ctrl(1, 1, 0, 1, 2, 0);
        wr(6'h01, 16'd2);
        repeat (2) @(negedge clk);
        chk("R9", "power low when idle", adc_power, 0);
        n0 = neos;
        fire(2'b01, c0);
        wait_end(n0, "R9");
        chk("R9", "samples", nlog, 3);
        chk("R9", "first delay", log_cyc[0] - c0, 25);
        chk("R9", "gap 1", log_cyc[1] - log_cyc[0], 25);
        chk("R9", "gap 2", log_cyc[2] - log_cyc[1], 25);
        chk("R9", "power after run", adc_power, 0);
        check_slots(0, 3, "R9");
    endtask

    task automatic t_sleep_list;
        int c0, n0;
        set_ctrl(1, 1, 0, 0, 2, 0);
        wr(6'h01, 16'd2);
        for (int r = 0; r < 2; r++) begin
            n0 = neos;
            fire(2'b01, c0);
            wait_end(n0, "R10");
            chk("R10", $sformatf("run %0d first delay", r), log_cyc[0] - c0, 25);
            chk("R10", $sformatf("run %0d gap", r), log_cyc[2] - log_cyc[0], 2);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_split_list0();
        t_split_list1();
        t_chain();
        t_overrun();
        t_sleep_each();
        t_sleep_list();
        finish_run();
    end

    initial begin
        #400000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule